// File: doc/BRIEF.md
# Programmable Interval Timer with Prescaler

This block is a 16-bit down-counting interval timer run through three halfword registers: a control/status word, a modulus word and a read-only view of the live count. The counter steps down once every 2^(PRE+1) system clocks. Here PRE is a 4-bit prescaler field, so the step rate is half the system clock divided by a power of two from 1 to 32768. When the counter is at zero and a step arrives, the counter wraps. In reload mode it wraps to the modulus, and in free-run mode it wraps to 0xFFFF. The same wrap sets an event flag.

The interrupt output is a level: it is high while both the flag and the interrupt-enable bit are set. Software clears the flag by writing a 1 to its bit, or as a side effect of writing the modulus. A control write that changes only the interrupt bits leaves the count and prescaler phase running. Any other control write restarts the timer. When the overwrite bit is set, a modulus write also loads the new value straight into the counter. Register reads are combinational from the offset on `reg_addr`. A write takes effect at the rising clock edge on which `reg_wr` is high.

Top module: `interval_timer`

## Requirements
- R1: After reset, the control word and the modulus read 0x0000, the count reads 0xFFFF, `irq` is low and the counter does not step.
- R2: Byte offsets decode as follows: 0 is control/status, 2 is modulus, 4 is count (read-only). Writes to offset 4 or to any other offset change nothing, and reads of any other offset return 0. Control bits are: bit0 enable, bit1 reload, bit2 flag, bit3 interrupt enable, bit4 overwrite, bit5 debug, bit6 doze, bits 11:8 prescaler select. All other bits read 0.
- R3: While enabled, the count decrements once every 2^(PRE+1) clocks. While disabled, it holds its value.
- R4: With reload set, a step that finds the count at 0 loads the modulus and sets the flag on the same edge.
- R5: With reload clear, a step that finds the count at 0 loads 0xFFFF and sets the flag on the same edge.
- R6: `irq` is high exactly when the flag and the interrupt-enable bit are both 1.
- R7: Writing 1 to control bit2 clears the flag. Writing 0 there leaves it unchanged.
- R8: A control write whose enable, reload, overwrite, debug, doze and prescaler fields equal the stored ones updates only the interrupt enable (and flag). The count and prescaler phase continue undisturbed.
- R9: Any other control write stores all fields, clears the prescaler phase and loads the counter with the new wrap value: the modulus if reload is set, otherwise 0xFFFF.
- R10: A modulus write clears the flag, unless an expiry happens on the same edge. In that case the flag is set.
- R11: With overwrite set, a modulus write loads the written value into the counter on that edge, in both modes. With overwrite clear in reload mode, the new modulus is used only at the next wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe, sampled on the rising edge |
| reg_addr | input | 3 | Byte offset of the register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data for `reg_addr` |
| irq | output | 1 | Level interrupt request |

## Verification
Every register write lands on the single clock edge where `reg_wr` is high, so readback and `irq` are due in the cycle after that edge. A restart write puts the wrap value on the count immediately. The first decrement then arrives exactly 2^(PRE+1) edges after the write, and the wrap comes (count+1)·2^(PRE+1) edges after it. The bench steps a behavioural model on each rising edge and compares the read data and `irq` two nanoseconds later, before any input moves at the falling edge. The directed checks count edges from the write edge using these latencies.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int REG_W   = 16;
    localparam int ADDR_W  = 3;
    localparam int PSEL_W  = 4;

    localparam int B_EN    = 0;
    localparam int B_RLD   = 1;
    localparam int B_FLAG  = 2;
    localparam int B_IE    = 3;
    localparam int B_OVW   = 4;
    localparam int B_DBG   = 5;
    localparam int B_DOZE  = 6;
    localparam int B_PSEL  = 8;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_MOD  = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_CNT  = 3'd4;

    typedef struct packed {
        logic [PSEL_W-1:0] psel;
        logic              doze;
        logic              dbg;
        logic              ovw;
        logic              ie;
        logic              rld;
        logic              en;
    } ctrl_t;

    typedef enum logic [1:0] {
        WR_NONE,
        WR_SOFT,
        WR_RESTART,
        WR_MOD
    } wr_kind_e;

    function automatic ctrl_t word_to_ctrl(logic [REG_W-1:0] w);
        ctrl_t c;
        c.en   = w[B_EN];
        c.rld  = w[B_RLD];
        c.ie   = w[B_IE];
        c.ovw  = w[B_OVW];
        c.dbg  = w[B_DBG];
        c.doze = w[B_DOZE];
        c.psel = w[B_PSEL +: PSEL_W];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] ctrl_to_word(ctrl_t c, logic flag);
        logic [REG_W-1:0] w;
        w = '0;
        w[B_EN]   = c.en;
        w[B_RLD]  = c.rld;
        w[B_FLAG] = flag;
        w[B_IE]   = c.ie;
        w[B_OVW]  = c.ovw;
        w[B_DBG]  = c.dbg;
        w[B_DOZE] = c.doze;
        w[B_PSEL +: PSEL_W] = c.psel;
        return w;
    endfunction

    // Mode fields equal, interrupt enable ignored
    function automatic logic same_mode(ctrl_t a, ctrl_t b);
        return (a.en == b.en) && (a.rld == b.rld) && (a.ovw == b.ovw) &&
               (a.dbg == b.dbg) && (a.doze == b.doze) && (a.psel == b.psel);
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int PSEL_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              clr,
    input  logic [PSEL_W-1:0] psel,
    output logic              tick
);
    localparam int DIV_W = 1 << PSEL_W;

    logic [DIV_W-1:0] phase;
    logic [DIV_W-1:0] last;

    // Period is 2^(psel+1) clocks: half the clock, then 2^psel
    always_comb begin
        last = DIV_W'((33'd2 << psel) - 33'd1);
    end

    assign tick = run && (phase == last);

    always_ff @(posedge clk) begin
        if (rst || clr || !run) begin
            phase <= '0;
        end else if (tick) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick); // R3

    AST_CLR_RESTARTS_PHASE: assert property (@(posedge clk) disable iff (rst)
        clr |=> !tick); // R9

endmodule

// File: rtl/tmr_downcount.sv
module tmr_downcount #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             restart,
    input  logic [CNT_W-1:0] restart_val,
    input  logic             ovw_load,
    input  logic [CNT_W-1:0] ovw_val,
    input  logic [CNT_W-1:0] wrap_val,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    assign expire = tick && (count == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '1;
        end else if (restart) begin
            count <= restart_val;
        end else if (ovw_load) begin
            count <= ovw_val;
        end else if (tick) begin
            count <= expire ? wrap_val : count - 1'b1;
        end
    end

    AST_WRAP_LOADS_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (expire && !restart && !ovw_load) |=> (count == $past(wrap_val))); // R4

    AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (rst)
        (!tick && !restart && !ovw_load) |=> $stable(count)); // R3

    AST_OVW_LOADS_COUNT: assert property (@(posedge clk) disable iff (rst)
        (ovw_load && !restart) |=> (count == $past(ovw_val))); // R11

endmodule

// File: rtl/tmr_regfile.sv
module tmr_regfile
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic              expire,
    output ctrl_t             ctrl,
    output logic              flag,
    output logic [REG_W-1:0]  modulus,
    output logic              restart,
    output logic [REG_W-1:0]  restart_val,
    output logic              ovw_load,
    output logic [REG_W-1:0]  wrap_val
);
    wr_kind_e kind;
    ctrl_t    new_ctrl;
    logic     ctrl_wr;

    assign new_ctrl = word_to_ctrl(reg_wdata);
    assign ctrl_wr  = reg_wr && (reg_addr == OFS_CTRL);

    always_comb begin
        kind = WR_NONE;
        if (ctrl_wr) begin
            kind = same_mode(ctrl, new_ctrl) ? WR_SOFT : WR_RESTART;
        end else if (reg_wr && (reg_addr == OFS_MOD)) begin
            kind = WR_MOD;
        end
    end

    assign restart     = (kind == WR_RESTART);
    assign restart_val = new_ctrl.rld ? modulus : '1;
    assign ovw_load    = (kind == WR_MOD) && ctrl.ovw;
    assign wrap_val    = ctrl.rld ? modulus : '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl    <= '0;
            modulus <= '0;
        end else begin
            case (kind)
                WR_SOFT:    ctrl.ie <= new_ctrl.ie;
                WR_RESTART: ctrl    <= new_ctrl;
                WR_MOD:     modulus <= reg_wdata;
                default:    ;
            endcase
        end
    end

    // Expiry wins over any clear on the same edge
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (expire) begin
            flag <= 1'b1;
        end else if (ctrl_wr && reg_wdata[B_FLAG]) begin
            flag <= 1'b0;
        end else if (kind == WR_MOD) begin
            flag <= 1'b0;
        end
    end

    AST_FLAG_ON_EXPIRY: assert property (@(posedge clk) disable iff (rst)
        expire |=> flag); // R4

    AST_MOD_WR_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && (reg_addr == OFS_MOD) && !expire) |=> !flag); // R10

    AST_ZERO_KEEPS_FLAG: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && !reg_wdata[B_FLAG] && flag) |=> flag); // R7

    AST_SOFT_KEEPS_MODE: assert property (@(posedge clk) disable iff (rst)
        (kind == WR_SOFT) |=> $stable(ctrl.psel) && $stable(ctrl.en)); // R8

endmodule

// File: rtl/interval_timer.sv
module interval_timer
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq
);
    ctrl_t            ctrl;
    logic             flag;
    logic [REG_W-1:0] modulus;
    logic             restart;
    logic [REG_W-1:0] restart_val;
    logic             ovw_load;
    logic [REG_W-1:0] wrap_val;
    logic [REG_W-1:0] count;
    logic             expire;
    logic             tick;

    tmr_regfile u_regs (
        .clk         (clk),
        .rst         (rst),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .expire      (expire),
        .ctrl        (ctrl),
        .flag        (flag),
        .modulus     (modulus),
        .restart     (restart),
        .restart_val (restart_val),
        .ovw_load    (ovw_load),
        .wrap_val    (wrap_val)
    );

    tmr_prescaler #(.PSEL_W(PSEL_W)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .run  (ctrl.en),
        .clr  (restart),
        .psel (ctrl.psel),
        .tick (tick)
    );

    tmr_downcount #(.CNT_W(REG_W)) u_cnt (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick),
        .restart     (restart),
        .restart_val (restart_val),
        .ovw_load    (ovw_load),
        .ovw_val     (reg_wdata),
        .wrap_val    (wrap_val),
        .count       (count),
        .expire      (expire)
    );

    always_comb begin
        case (reg_addr)
            OFS_CTRL: reg_rdata = ctrl_to_word(ctrl, flag);
            OFS_MOD:  reg_rdata = modulus;
            OFS_CNT:  reg_rdata = count;
            default:  reg_rdata = '0;
        endcase
    end

    assign irq = flag && ctrl.ie;

    AST_IDLE_NO_STEP: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.en && !restart && !ovw_load) |=> $stable(count)); // R3

    AST_IRQ_FALLS_ON_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && (reg_addr == OFS_CTRL) && reg_wdata[B_FLAG] && !expire) |=> !irq); // R6

endmodule

// File: tb/sim_interval_timer.sv
module sim_interval_timer;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr;
    logic [2:0]  reg_addr;
    logic [15:0] reg_wdata;
    logic [15:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    interval_timer u0 (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    // Behavioural reference model
    bit m_en, m_rld, m_flag, m_ie, m_ovw, m_dbg, m_doze;
    int m_pre, m_mod, m_cnt, m_phase;
    int per, n_phase, n_cnt;
    bit tk, ex, n_flag;

    always @(posedge clk) begin
        if (rst) begin
            {m_en, m_rld, m_flag, m_ie, m_ovw, m_dbg, m_doze} = '0;
            m_pre = 0; m_mod = 0; m_cnt = 65535; m_phase = 0;
        end else begin
            per     = 2 << m_pre;
            tk      = m_en && (m_phase == per - 1);
            ex      = tk && (m_cnt == 0);
            n_phase = !m_en ? 0 : (tk ? 0 : m_phase + 1);
            n_cnt   = tk ? (ex ? (m_rld ? m_mod : 65535) : m_cnt - 1) : m_cnt;
            n_flag  = m_flag;
            if (reg_wr && reg_addr == 3'd0) begin
                if (reg_wdata[2]) n_flag = 0;
                if (reg_wdata[0] == m_en && reg_wdata[1] == m_rld &&
                    reg_wdata[4] == m_ovw && reg_wdata[5] == m_dbg &&
                    reg_wdata[6] == m_doze && int'(reg_wdata[11:8]) == m_pre) begin
                    m_ie = reg_wdata[3];
                end else begin
                    m_en = reg_wdata[0]; m_rld = reg_wdata[1]; m_ie = reg_wdata[3];
                    m_ovw = reg_wdata[4]; m_dbg = reg_wdata[5]; m_doze = reg_wdata[6];
                    m_pre = int'(reg_wdata[11:8]);
                    n_phase = 0;
                    n_cnt = reg_wdata[1] ? m_mod : 65535;
                end
            end else if (reg_wr && reg_addr == 3'd2) begin
                n_flag = 0;
                if (m_ovw) n_cnt = int'(reg_wdata);
                m_mod = int'(reg_wdata);
            end
            if (ex) n_flag = 1;
            m_phase = n_phase;
            m_cnt   = n_cnt;
            m_flag  = n_flag;
        end
    end

    function automatic logic [15:0] m_read(logic [2:0] a);
        case (a)
            3'd0: return {4'b0, 4'(m_pre), 1'b0, m_doze, m_dbg, m_ovw, m_ie, m_flag, m_rld, m_en};
            3'd2: return 16'(m_mod);
            3'd4: return 16'(m_cnt);
            default: return 16'h0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison, 2 ns after each rising edge
    always @(posedge clk) begin
        #2;
        if (!rst && !done) begin
            check("R2 per-cycle readback", reg_rdata, m_read(reg_addr));
            check("R6 per-cycle irq", {15'b0, irq}, {15'b0, m_flag && m_ie});
        end
    end

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [15:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic finish_run;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic [15:0] v;
        rst = 1'b1; reg_wr = 1'b0; reg_addr = 3'd0; reg_wdata = 16'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        peek(3'd0, v); check("R1 ctrl after reset", v, 16'h0000);
        peek(3'd2, v); check("R1 modulus after reset", v, 16'h0000);
        peek(3'd4, v); check("R1 count after reset", v, 16'hFFFF);
        check("R1 irq after reset", {15'b0, irq}, 16'h0);
        edges(5);
        peek(3'd4, v); check("R1 count idle", v, 16'hFFFF);

        // R2 decode and ignored writes
        wr(3'd2, 16'h0005);
        peek(3'd2, v); check("R2 modulus readback", v, 16'h0005);
        wr(3'd4, 16'h1234);
        peek(3'd4, v); check("R2 count write ignored", v, 16'hFFFF);
        wr(3'd6, 16'hBEEF);
        peek(3'd6, v); check("R2 unused offset reads 0", v, 16'h0000);
        peek(3'd2, v); check("R2 unused offset write ignored", v, 16'h0005);
        wr(3'd0, 16'hF0F8);
        peek(3'd0, v); check("R2 unused ctrl bits read 0", v, 16'h0078);

        // R3 prescaler rate, PRE=2 -> 8 clocks per step
        wr(3'd0, 16'h0201);
        peek(3'd4, v); check("R9 free restart loads FFFF", v, 16'hFFFF);
        edges(23);
        peek(3'd4, v); check("R3 two steps after 23 clocks", v, 16'hFFFD);
        edges(1);
        peek(3'd4, v); check("R3 three steps after 24 clocks", v, 16'hFFFC);

        // R4 reload wrap
        wr(3'd2, 16'h0003);
        wr(3'd0, 16'h000B);
        edges(7);
        peek(3'd4, v); check("R4 count at zero", v, 16'h0000);
        check("R4 no irq before wrap", {15'b0, irq}, 16'h0);
        edges(1);
        peek(3'd4, v); check("R4 reload to modulus", v, 16'h0003);
        peek(3'd0, v); check("R4 flag set on wrap", v, 16'h000F);
        check("R6 irq with flag and enable", {15'b0, irq}, 16'h1);

        // R7 write-one-to-clear
        wr(3'd0, 16'h000B);
        peek(3'd0, v); check("R7 zero keeps flag", v, 16'h000F);
        wr(3'd0, 16'h000F);
        peek(3'd0, v); check("R7 one clears flag", v, 16'h000B);
        check("R6 irq low after clear", {15'b0, irq}, 16'h0);

        // R8 interrupt-only write does not restart
        wr(3'd0, 16'h0013);
        edges(4);
        wr(3'd0, 16'h001B);
        peek(3'd4, v); check("R8 count not restarted", v, 16'h0001);
        edges(1);
        peek(3'd4, v); check("R8 count keeps stepping", v, 16'h0000);

        // R5 free-run wrap with R11 overwrite
        wr(3'd0, 16'h0019);
        wr(3'd2, 16'h0002);
        peek(3'd4, v); check("R11 overwrite in free-run", v, 16'h0002);
        for (int i = 0; i < 20 && !irq; i++) edges(1);
        check("R5 flag raised on free wrap", {15'b0, irq}, 16'h1);
        peek(3'd4, v); check("R5 free wrap to FFFF", v, 16'hFFFF);

        // R6 flag without enable keeps irq low
        wr(3'd0, 16'h0011);
        peek(3'd0, v); check("R6 flag kept", v, 16'h0015);
        check("R6 irq low without enable", {15'b0, irq}, 16'h0);

        // R10 modulus write clears flag
        wr(3'd2, 16'h0007);
        peek(3'd0, v); check("R10 modulus write clears flag", v, 16'h0011);
        peek(3'd4, v); check("R11 overwrite loads 7", v, 16'h0007);

        // R11 no overwrite: new modulus waits for wrap
        wr(3'd0, 16'h0003);
        wr(3'd2, 16'h0002);
        peek(3'd4, v); check("R11 no immediate load", v, 16'h0006);
        for (int i = 0; i < 40; i++) begin
            peek(3'd0, v);
            if (v[2]) break;
            edges(1);
        end
        peek(3'd0, v); check("R4 flag after reload wrap", v, 16'h0007);
        peek(3'd4, v); check("R11 new modulus used at wrap", v, 16'h0002);

        // R9 restart with new prescaler, PRE=1 -> 4 clocks per step
        wr(3'd0, 16'h0107);
        peek(3'd4, v); check("R9 restart loads modulus", v, 16'h0002);
        edges(3);
        peek(3'd4, v); check("R9 phase cleared, no step yet", v, 16'h0002);
        edges(1);
        peek(3'd4, v); check("R3 step after 4 clocks", v, 16'h0001);

        // R3 disabled counter holds
        wr(3'd0, 16'h0000);
        peek(3'd4, v); check("R9 disable restart loads FFFF", v, 16'hFFFF);
        edges(10);
        peek(3'd4, v); check("R3 disabled holds", v, 16'hFFFF);

        finish_run();
    end

endmodule